// File: doc/BRIEF.md
# Time base and decrementer unit

This unit keeps two 64-bit up-counting time bases, a main one and an alternate one, and one 32-bit down-counting decrementer. All three advance only on clock cycles where the single-cycle `tick` input is high. The run enable `run_en` freezes both time bases and later lets them resume from the frozen value. The decrementer does not look at `run_en`.

Software writes through one write port. A 3-bit target code selects either half of either time base, or the decrementer. Writing one half of a time base leaves the other half untouched. All counter values are visible on output ports at all times.

The decrementer raises a sticky interrupt flag in three cases: when it wraps from zero to all ones, when a write sets its sign bit while the current value has that bit clear, and, in saturating mode, when it reaches zero. The flag is cleared by a one-cycle acknowledge.

Top module: `tbase_dec_unit`

## Requirements
- R1: After reset both time bases read 0, the decrementer reads 0xFFFFFFFF and `dec_irq` is low. The reset load of the decrementer raises no interrupt.
- R2: With `run_en` high and no write to it, a time base increases by exactly 1 on each cycle where `tick` is high. It holds on cycles where `tick` is low. The carry propagates from bit 31 into bit 32.
- R3: While `run_en` is low, neither time base changes on a tick. Once `run_en` returns high, counting resumes from the held value.
- R4: Code 0 (`wr_sel`=3'd0) loads `wr_data` into bits 31:0 of the main time base and keeps bits 63:32. Code 1 loads bits 63:32 and keeps bits 31:0. A write in the same cycle as a tick takes precedence, so no increment happens in that cycle.
- R5: Codes 2 and 3 write the low and high halves of the alternate time base under the same rules as R4. Writes to one time base never alter the other.
- R6: With `sat_mode` low, each tick lowers the decrementer by 1. A tick at 0 yields 0xFFFFFFFF and sets `dec_irq`. Counting then continues down from 0xFFFFFFFF.
- R7: Code 4 loads `wr_data` into the decrementer, with precedence over a same-cycle tick. If `wr_data` bit 31 is 1 while the current decrementer bit 31 is 0, `dec_irq` is set on that same edge. A write of a value with bit 31 set over a value that already has bit 31 set does not set `dec_irq`.
- R8: With `sat_mode` high (embedded mode), a tick at value 1 gives 0 and sets `dec_irq`. A tick at 0 leaves the decrementer at 0, with no wrap and no interrupt.
- R9: `dec_irq` stays high until a cycle with `irq_ack` high clears it. If a set condition and `irq_ack` occur in the same cycle, the flag ends up set.
- R10: Writes with codes 5, 6 and 7 change no counter and no flag.
- R11: The decrementer keeps counting ticks while `run_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick | input | 1 | Count enable, one cycle per time-base period |
| run_en | input | 1 | High lets both time bases count; low freezes them |
| sat_mode | input | 1 | High: decrementer stops at zero (embedded mode) |
| wr_en | input | 1 | Software write strobe |
| wr_sel | input | 3 | Write target: 0 main low, 1 main high, 2 alternate low, 3 alternate high, 4 decrementer |
| wr_data | input | 32 | Write data |
| irq_ack | input | 1 | Clears the decrementer interrupt flag |
| tb_value | output | 64 | Main time base |
| atb_value | output | 64 | Alternate time base |
| dec_value | output | 32 | Decrementer |
| dec_irq | output | 1 | Sticky decrementer interrupt flag |

## Verification
The collision that matters is a software write landing in the same cycle as a tick. The written half or the decrementer must take the written value with no extra step, and a sign-setting decrementer write must still raise the flag. The bench provokes this deliberately: it writes near the wrap points (low half 0xFFFFFFFE, decrementer near zero) with `tick` high. It also acknowledges the flag in the very cycle an underflow sets it. A behavioural model compares every output after every clock, over directed cases and a random stretch where writes, ticks and acknowledges overlap freely.

// File: rtl/tbase_pkg.sv
package tbase_pkg;

   // Software write target codes
   typedef enum logic [2:0] {
      SEL_TB_LO  = 3'd0,
      SEL_TB_HI  = 3'd1,
      SEL_ATB_LO = 3'd2,
      SEL_ATB_HI = 3'd3,
      SEL_DEC    = 3'd4
   } wr_target_e;

   localparam int SEL_W = 3;

   // True when a loaded value turns the sign bit on
   function automatic logic sign_turns_on(input logic new_msb, input logic old_msb);
      return new_msb & ~old_msb;
   endfunction

endpackage

// File: rtl/tb_counter.sv
module tb_counter #(
   parameter int CNT_W  = 64,
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              run,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [WORD_W-1:0] wr_data,
   output logic [CNT_W-1:0]  count
);
   localparam int HI_W = CNT_W - WORD_W;

   initial begin : p_param_chk
      assert (CNT_W == 2 * WORD_W) else $fatal(1, "tb_counter: CNT_W must be twice WORD_W");
   end

   logic [CNT_W-1:0] nxt;

   always_comb begin
      nxt = count;
      if (wr_lo) begin
         nxt[WORD_W-1:0] = wr_data;
      end else if (wr_hi) begin
         nxt[CNT_W-1:WORD_W] = wr_data[HI_W-1:0];
      end else if (tick && run) begin
         nxt = count + CNT_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) count <= '0;
      else        count <= nxt;
   end

   a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && run && !wr_lo && !wr_hi) |=> count == $past(count) + CNT_W'(1));

   a_r3_freeze: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !wr_lo && !wr_hi) |=> $stable(count));

   a_r4_lo_keeps_hi: assert property (@(posedge clk) disable iff (!rst_n)
      wr_lo |=> (count[CNT_W-1:WORD_W] == $past(count[CNT_W-1:WORD_W]))
                && (count[WORD_W-1:0] == $past(wr_data)));

   a_r4_hi_keeps_lo: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hi && !wr_lo) |=> (count[WORD_W-1:0] == $past(count[WORD_W-1:0])));

endmodule

// File: rtl/dec_counter.sv
module dec_counter #(
   parameter int W           = 32,
   parameter bit EMB_SUPPORT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         sat_mode,
   input  logic         wr,
   input  logic [W-1:0] wr_data,
   output logic [W-1:0] count,
   output logic         event_o
);
   import tbase_pkg::*;

   localparam logic [W-1:0] ONE = W'(1);

   initial begin : p_param_chk
      assert (W >= 2) else $fatal(1, "dec_counter: W too small");
   end

   logic sat_eff;

   generate
      if (EMB_SUPPORT) begin : g_sat
         assign sat_eff = sat_mode;
      end else begin : g_wrap_only
         logic unused_sat;
         assign unused_sat = sat_mode;
         assign sat_eff    = 1'b0;
      end
   endgenerate

   logic [W-1:0] nxt;

   always_comb begin
      nxt     = count;
      event_o = 1'b0;
      if (wr) begin
         nxt     = wr_data;
         event_o = sign_turns_on(wr_data[W-1], count[W-1]);
      end else if (tick) begin
         if (sat_eff) begin
            if (count != '0) nxt = count - ONE;
            event_o = (count == ONE);
         end else begin
            nxt     = count - ONE;
            event_o = (count == '0);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) count <= '1;
      else        count <= nxt;
   end

   a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !wr && !sat_eff) |=> count == $past(count) - ONE);

   a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !wr && !sat_eff && count == '0) |=> count == '1);

   a_r8_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (sat_eff && !wr && count == '0) |=> count == '0);

   a_r7_load: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> count == $past(wr_data));

endmodule

// File: rtl/irq_flag.sv
module irq_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic ack,
   output logic flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   flag <= 1'b0;
      else if (set) flag <= 1'b1;
      else if (ack) flag <= 1'b0;
   end

   a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !ack) |=> flag);

   a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set |=> flag);

   a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !set) |=> !flag);

endmodule

// File: rtl/tbase_dec_unit.sv
module tbase_dec_unit #(
   parameter int WORD_W      = 32,
   parameter bit EMB_SUPPORT = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick,
   input  logic                run_en,
   input  logic                sat_mode,
   input  logic                wr_en,
   input  logic [2:0]          wr_sel,
   input  logic [WORD_W-1:0]   wr_data,
   input  logic                irq_ack,
   output logic [2*WORD_W-1:0] tb_value,
   output logic [2*WORD_W-1:0] atb_value,
   output logic [WORD_W-1:0]   dec_value,
   output logic                dec_irq
);
   import tbase_pkg::*;

   localparam int TB_W      = 2 * WORD_W;
   localparam int NUM_BASES = 2;

   initial begin : p_param_chk
      assert (WORD_W >= 8) else $fatal(1, "tbase_dec_unit: WORD_W too small");
   end

   // Write decode: base i owns codes 2*i (low) and 2*i+1 (high)
   logic [NUM_BASES-1:0] wr_lo_v, wr_hi_v;
   logic [TB_W-1:0]      tb_cnt [NUM_BASES];
   logic                 wr_dec;
   logic                 dec_event;

   generate
      for (genvar i = 0; i < NUM_BASES; i++) begin : g_tb
         assign wr_lo_v[i] = wr_en && (wr_sel == SEL_W'(2 * i));
         assign wr_hi_v[i] = wr_en && (wr_sel == SEL_W'(2 * i + 1));

         tb_counter #(
            .CNT_W  (TB_W),
            .WORD_W (WORD_W)
         ) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick),
            .run     (run_en),
            .wr_lo   (wr_lo_v[i]),
            .wr_hi   (wr_hi_v[i]),
            .wr_data (wr_data),
            .count   (tb_cnt[i])
         );
      end
   endgenerate

   assign tb_value  = tb_cnt[0];
   assign atb_value = tb_cnt[1];
   assign wr_dec    = wr_en && (wr_sel == SEL_DEC);

   dec_counter #(
      .W           (WORD_W),
      .EMB_SUPPORT (EMB_SUPPORT)
   ) u_dec (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .sat_mode (sat_mode),
      .wr       (wr_dec),
      .wr_data  (wr_data),
      .count    (dec_value),
      .event_o  (dec_event)
   );

   irq_flag u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (dec_event),
      .ack   (irq_ack),
      .flag  (dec_irq)
   );

   a_r7_sign_write_irq: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == SEL_DEC && wr_data[WORD_W-1] && !dec_value[WORD_W-1]) |=> dec_irq);

   a_r10_unused_codes: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel > SEL_DEC && !tick && !irq_ack)
      |=> $stable(tb_value) && $stable(atb_value) && $stable(dec_value) && $stable(dec_irq));

   a_r5_bases_apart: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_lo_v[1] || wr_hi_v[1]) && !tick |=> $stable(tb_value));

   a_r11_dec_ignores_run: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_en && tick && !wr_dec && !sat_mode) |=> dec_value != $past(dec_value));

endmodule

// File: tb/tbase_dec_unit_test.sv
module tbase_dec_unit_test;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        tick, run_en, sat_mode, wr_en, irq_ack;
   logic [2:0]  wr_sel;
   logic [31:0] wr_data;
   logic [63:0] tb_value, atb_value;
   logic [31:0] dec_value;
   logic        dec_irq;

   always #5 clk = ~clk;

   tbase_dec_unit uut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .run_en(run_en), .sat_mode(sat_mode),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .irq_ack(irq_ack),
      .tb_value(tb_value), .atb_value(atb_value), .dec_value(dec_value), .dec_irq(dec_irq)
   );

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   // reference model state
   logic [63:0] m_tb, m_atb;
   logic [31:0] m_dec;
   logic        m_irq;

   task automatic compare(string tag);
      checks++;
      if (tb_value !== m_tb) begin
         errors++;
         $display("FAIL %s tb actual=%h expected=%h", tag, tb_value, m_tb);
      end
      checks++;
      if (atb_value !== m_atb) begin
         errors++;
         $display("FAIL %s atb actual=%h expected=%h", tag, atb_value, m_atb);
      end
      checks++;
      if (dec_value !== m_dec) begin
         errors++;
         $display("FAIL %s dec actual=%h expected=%h", tag, dec_value, m_dec);
      end
      checks++;
      if (dec_irq !== m_irq) begin
         errors++;
         $display("FAIL %s irq actual=%b expected=%b", tag, dec_irq, m_irq);
      end
   endtask

   task automatic model_step(logic t, logic r, logic s, logic we, logic [2:0] sel,
                             logic [31:0] d, logic ack);
      bit set = 0;
      if (we && sel == 3'd0)      m_tb = {m_tb[63:32], d};
      else if (we && sel == 3'd1) m_tb = {d, m_tb[31:0]};
      else if (t && r)            m_tb = m_tb + 64'd1;
      if (we && sel == 3'd2)      m_atb = {m_atb[63:32], d};
      else if (we && sel == 3'd3) m_atb = {d, m_atb[31:0]};
      else if (t && r)            m_atb = m_atb + 64'd1;
      if (we && sel == 3'd4) begin
         if (d[31] && !m_dec[31]) set = 1;
         m_dec = d;
      end else if (t) begin
         if (s) begin
            if (m_dec == 32'd1) set = 1;
            if (m_dec != 32'd0) m_dec = m_dec - 32'd1;
         end else begin
            if (m_dec == 32'd0) set = 1;
            m_dec = m_dec - 32'd1;
         end
      end
      if (set)      m_irq = 1'b1;
      else if (ack) m_irq = 1'b0;
   endtask

   task automatic cyc(string tag, logic t, logic r, logic s, logic we,
                      logic [2:0] sel, logic [31:0] d, logic ack);
      tick = t; run_en = r; sat_mode = s; wr_en = we; wr_sel = sel; wr_data = d; irq_ack = ack;
      @(posedge clk);
      model_step(t, r, s, we, sel, d, ack);
      #1;
      compare(tag);
   endtask

   task automatic do_reset();
      rst_n = 1'b0; tick = 0; run_en = 0; sat_mode = 0; wr_en = 0;
      wr_sel = 0; wr_data = 0; irq_ack = 0;
      repeat (3) @(posedge clk);
      #1;
      m_tb = '0; m_atb = '0; m_dec = 32'hFFFF_FFFF; m_irq = 1'b0;
      rst_n = 1'b1;
      compare("R1 reset state");
   endtask

   initial begin : watchdog
      #1500us;
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : stimulus
      do_reset();
      cyc("R1 idle after reset", 0, 1, 0, 0, 0, 0, 0);

      // R2 counting and holding
      for (int i = 0; i < 5; i++) cyc("R2 tick count", 1, 1, 0, 0, 0, 0, 0);
      cyc("R2 no tick hold", 0, 1, 0, 0, 0, 0, 0);
      cyc("R2 no tick hold", 0, 1, 0, 0, 0, 0, 0);

      // R3 freeze and resume; R11 decrementer keeps going
      for (int i = 0; i < 4; i++) cyc("R3 frozen R11", 1, 0, 0, 0, 0, 0, 0);
      for (int i = 0; i < 3; i++) cyc("R3 resume", 1, 1, 0, 0, 0, 0, 0);

      // R4 half writes, write over tick, carry
      cyc("R4 lo write over tick", 1, 1, 0, 1, 3'd0, 32'hFFFF_FFFE, 0);
      for (int i = 0; i < 3; i++) cyc("R2 carry into hi", 1, 1, 0, 0, 0, 0, 0);
      cyc("R4 hi write over tick", 1, 1, 0, 1, 3'd1, 32'h1234_5678, 0);
      cyc("R4 after hi write", 1, 1, 0, 0, 0, 0, 0);

      // R5 alternate base
      cyc("R5 atb lo write", 1, 1, 0, 1, 3'd2, 32'hAAAA_0000, 0);
      cyc("R5 atb hi write", 0, 1, 0, 1, 3'd3, 32'h0000_0005, 0);
      cyc("R5 atb counts", 1, 1, 0, 0, 0, 0, 0);

      // R6 wrap underflow
      cyc("R7 positive load", 0, 1, 0, 1, 3'd4, 32'd2, 0);
      for (int i = 0; i < 4; i++) cyc("R6 decrement wrap", 1, 1, 0, 0, 0, 0, 0);
      cyc("R9 sticky", 0, 1, 0, 0, 0, 0, 0);
      cyc("R9 ack clears", 0, 1, 0, 0, 0, 0, 1);
      cyc("R9 ack idle", 0, 1, 0, 0, 0, 0, 1);

      // R7 sign-setting writes
      cyc("R7 neg over neg no irq", 0, 1, 0, 1, 3'd4, 32'h8000_0000, 0);
      cyc("R7 positive load", 0, 1, 0, 1, 3'd4, 32'd5, 0);
      cyc("R7 sign rise irq", 0, 1, 0, 1, 3'd4, 32'h8000_0001, 0);
      cyc("R9 ack", 0, 1, 0, 0, 0, 0, 1);
      cyc("R7 write over tick", 1, 1, 0, 1, 3'd4, 32'd7, 0);

      // R8 saturating mode
      cyc("R8 load", 0, 1, 1, 1, 3'd4, 32'd3, 0);
      for (int i = 0; i < 5; i++) cyc("R8 saturate at zero", 1, 1, 1, 0, 0, 0, 0);
      cyc("R8 ack", 0, 1, 1, 0, 0, 0, 1);
      cyc("R8 stays zero no irq", 1, 1, 1, 0, 0, 0, 0);
      cyc("R6 wrap after mode change", 1, 1, 0, 0, 0, 0, 0);

      // R9 set and ack in the same cycle
      cyc("R9 ack", 0, 1, 0, 0, 0, 0, 1);
      cyc("R7 zero load", 0, 1, 0, 1, 3'd4, 32'd0, 0);
      cyc("R9 set beats ack", 1, 1, 0, 0, 0, 0, 1);
      cyc("R9 ack later", 0, 1, 0, 0, 0, 0, 1);

      // R10 unused codes
      cyc("R10 code 5", 0, 1, 0, 1, 3'd5, 32'hDEAD_BEEF, 0);
      cyc("R10 code 6", 0, 1, 0, 1, 3'd6, 32'h8000_0000, 0);
      cyc("R10 code 7", 0, 1, 0, 1, 3'd7, 32'h0BAD_F00D, 0);

      // mixed random traffic
      for (int i = 0; i < 3000; i++) begin
         logic [2:0]  rsel = 3'($urandom_range(0, 7));
         logic [31:0] rdat = (($urandom % 4) == 0) ? 32'($urandom_range(0, 3)) : $urandom;
         cyc("R6 R7 R9 random mix", 1'($urandom % 3 != 0), 1'($urandom % 5 != 0),
             1'($urandom % 4 == 0), 1'($urandom % 6 == 0), rsel, rdat,
             1'($urandom % 7 == 0));
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule